// File: doc/BRIEF.md
# Hamming Single-Error Correcting Codec

This block holds a Hamming encoder and a Hamming decoder, side by side, each with its own valid-qualified, registered path. The encoder takes a data word and builds a codeword with check bits at every power-of-two position. Positions count from 1. The data bits fill the other positions in rising order. Each check bit makes even parity over the positions whose binary index has that check's bit set.

The decoder recomputes every check on a received codeword and packs the results into a syndrome. Read as a binary number, the syndrome names the one position to invert. When the syndrome is zero, the word passes through unchanged. When the syndrome points past the end of the codeword, the decoder raises a flag and inverts nothing.

The data width is a parameter. The number of check bits is derived from it.

Top module: `hsc_codec`

## Requirements
- R1: The check-bit count is the smallest k with 2^k >= DATA_W + k + 1. The codeword is DATA_W + k bits wide: 7 bits for 4 data bits and 9 bits for 5 data bits.
- R2: Codeword vector bit i holds position i+1. Check bits sit at positions 1, 2, 4 and so on. Data bit 0 goes to the lowest other position, and the rest follow in rising order. With 4 data bits, data 1010 encodes to 1010010 (vector bit 6 down to bit 0).
- R3: Check bit j is chosen so that the XOR over all positions with bit j of their index set is zero (even parity).
- R4: Syndrome bit j is the recomputed check j, so the highest check is the MSB. A received 1110010 gives syndrome 110. With 5 data bits, a single inversion at position 5 gives syndrome 0101.
- R5: For a syndrome from 1 to the codeword length, the bit at that position is inverted before the data is extracted, and the corrected flag is 1.
- R6: For a zero syndrome, the data is extracted unchanged, and both the corrected flag and the uncorrectable flag are 0.
- R7: For a syndrome above the codeword length, the uncorrectable flag is 1, the corrected flag is 0, and the data is extracted with no bit inverted.
- R8: Each path has a latency of one clock. An output valid equals its input valid one cycle earlier. While the input valid is low, the path's data outputs hold their values.
- R9: A synchronous active-low reset clears both output valids and all data, syndrome and flag outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_valid_i | input | 1 | Encoder input qualifier |
| enc_data_i | input | DATA_W | Data word to encode |
| enc_valid_o | output | 1 | Encoder output qualifier |
| enc_code_o | output | CODE_W | Encoded codeword, bit i = position i+1 |
| dec_valid_i | input | 1 | Decoder input qualifier |
| dec_code_i | input | CODE_W | Received codeword |
| dec_valid_o | output | 1 | Decoder output qualifier |
| dec_data_o | output | DATA_W | Corrected data |
| dec_syndrome_o | output | PAR_W | Syndrome of the received word |
| dec_fixed_o | output | 1 | A bit was inverted |
| dec_uncorr_o | output | 1 | Syndrome points beyond the codeword |

## Verification
A wrong coverage mask or a wrong data-position table shows up in the very next cycle. It appears as a nonzero syndrome on a freshly encoded word, or as an expected codeword that differs in a fixed bit. Every received word of a 7-bit and of a 9-bit configuration is applied. Each is compared with a syndrome the bench forms as the XOR of the indices of the set positions. Any slip in the flip decoder or in the range test therefore surfaces as a mismatched data bit or flag within one cycle of that pattern.

// File: rtl/hsc_pkg.sv
// Shared helpers for the Hamming codec.
// Assumes positions are numbered from 1 and check bits sit at powers of two.
package hsc_pkg;

    // Smallest k such that 2^k >= m + k + 1.
    function automatic int par_width(input int m);
        int k;
        k = 1;
        for (int t = 1; t < 31; t++) begin
            if ((1 << k) < m + k + 1) k = t + 1;
        end
        return k;
    endfunction

    // True when the 1-based position holds a check bit.
    function automatic bit is_check_pos(input int pos);
        return (pos > 0) && ((pos & (pos - 1)) == 0);
    endfunction

    // 1-based position of data bit idx (data fills non-check positions upward).
    function automatic int data_pos(input int idx);
        int seen;
        int found;
        seen  = 0;
        found = 0;
        for (int p = 1; p < 4096; p++) begin
            if (!is_check_pos(p) && found == 0) begin
                if (seen == idx) found = p;
                seen++;
            end
        end
        return found;
    endfunction

    // True when check j covers the 1-based position pos.
    function automatic bit covers(input int pos, input int chk);
        return ((pos >> chk) & 1) == 1;
    endfunction

endpackage

// File: rtl/hsc_encoder.sv
// Hamming encoder: places data at non-power-of-two positions and fills
// each check bit for even parity over its covered positions.
// Assumes one word per valid cycle; output is registered.
module hsc_encoder
    import hsc_pkg::*;
#(
    parameter int DATA_W = 4,
    parameter int PAR_W  = par_width(DATA_W),
    parameter int CODE_W = DATA_W + PAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              valid_o,
    output logic [CODE_W-1:0] code_o
);

    logic [CODE_W-1:0] word;

    // Build the codeword: scatter data, then compute each check bit.
    always_comb begin
        word = '0;
        for (int i = 0; i < DATA_W; i++) begin
            word[data_pos(i) - 1] = data_i[i];
        end
        for (int j = 0; j < PAR_W; j++) begin
            for (int p = 1; p <= CODE_W; p++) begin
                if (covers(p, j) && !is_check_pos(p))
                    word[(1 << j) - 1] = word[(1 << j) - 1] ^ word[p - 1];
            end
        end
    end

    // Output register with valid-qualified load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            code_o  <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) code_o <= word;
        end
    end

    // Recheck of the registered codeword, used only by the assertion.
    function automatic logic [PAR_W-1:0] recheck(input logic [CODE_W-1:0] w);
        logic [PAR_W-1:0] s;
        s = '0;
        for (int j = 0; j < PAR_W; j++)
            for (int p = 1; p <= CODE_W; p++)
                if (covers(p, j)) s[j] = s[j] ^ w[p - 1];
        return s;
    endfunction

    a_r3_enc_even_parity: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (recheck(code_o) == '0));
    a_r8_enc_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);
    a_r8_enc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(code_o));
    a_r9_enc_reset: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && code_o == '0));

endmodule

// File: rtl/hsc_syndrome.sv
// Syndrome generator: recomputes every check over the received word.
// Bit j of the result is check j, so its value is the 1-based error position.
module hsc_syndrome
    import hsc_pkg::*;
#(
    parameter int CODE_W = 7,
    parameter int PAR_W  = 3
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [PAR_W-1:0]  syn_o
);

    // XOR of the covered positions for each check.
    always_comb begin
        syn_o = '0;
        for (int j = 0; j < PAR_W; j++)
            for (int p = 1; p <= CODE_W; p++)
                if (covers(p, j)) syn_o[j] = syn_o[j] ^ code_i[p - 1];
    end

endmodule

// File: rtl/hsc_decoder.sv
// Hamming decoder: forms the syndrome, inverts the named position when it
// lies inside the word, flags syndromes beyond the word, extracts data.
// Assumes at most one bit in error; output is registered.
module hsc_decoder
    import hsc_pkg::*;
#(
    parameter int DATA_W = 4,
    parameter int PAR_W  = par_width(DATA_W),
    parameter int CODE_W = DATA_W + PAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic [PAR_W-1:0]  syn_o,
    output logic              fixed_o,
    output logic              uncorr_o
);

    logic [PAR_W-1:0]  syn;
    logic              in_range;
    logic              beyond;
    logic [CODE_W-1:0] flip;
    logic [CODE_W-1:0] repaired;
    logic [DATA_W-1:0] extracted;

    hsc_syndrome #(.CODE_W(CODE_W), .PAR_W(PAR_W)) u_syn (
        .code_i (code_i),
        .syn_o  (syn)
    );

    // Classify the syndrome against the codeword length.
    always_comb begin
        in_range = (syn != '0) && (int'(syn) <= CODE_W);
        beyond   = int'(syn) > CODE_W;
    end

    // One-hot inversion mask for the named position.
    always_comb begin
        for (int p = 1; p <= CODE_W; p++)
            flip[p - 1] = in_range && (syn == PAR_W'(p));
        repaired = code_i ^ flip;
    end

    // Gather data bits from their positions.
    always_comb begin
        for (int i = 0; i < DATA_W; i++)
            extracted[i] = repaired[data_pos(i) - 1];
    end

    // Output register with valid-qualified load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o  <= 1'b0;
            data_o   <= '0;
            syn_o    <= '0;
            fixed_o  <= 1'b0;
            uncorr_o <= 1'b0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                data_o   <= extracted;
                syn_o    <= syn;
                fixed_o  <= in_range;
                uncorr_o <= beyond;
            end
        end
    end

    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fixed_o && uncorr_o));
    a_r5_fixed_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        fixed_o |-> (syn_o != '0 && int'(syn_o) <= CODE_W));
    a_r6_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (syn_o == '0) |-> (!fixed_o && !uncorr_o));
    a_r5_single_flip: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(flip) <= 1);
    a_r8_dec_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);
    a_r8_dec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(data_o) && $stable(syn_o)));
    a_r9_dec_reset: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && data_o == '0 && !fixed_o && !uncorr_o));

endmodule

// File: rtl/hsc_codec.sv
// Top of the Hamming single-error codec: independent registered encode
// and decode paths sharing one clock and reset.
// Assumes DATA_W >= 1; the check count is derived from it.
module hsc_codec
    import hsc_pkg::*;
#(
    parameter int DATA_W = 4,
    localparam int PAR_W  = par_width(DATA_W),
    localparam int CODE_W = DATA_W + PAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_valid_i,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic              enc_valid_o,
    output logic [CODE_W-1:0] enc_code_o,
    input  logic              dec_valid_i,
    input  logic [CODE_W-1:0] dec_code_i,
    output logic              dec_valid_o,
    output logic [DATA_W-1:0] dec_data_o,
    output logic [PAR_W-1:0]  dec_syndrome_o,
    output logic              dec_fixed_o,
    output logic              dec_uncorr_o
);

    hsc_encoder #(.DATA_W(DATA_W), .PAR_W(PAR_W), .CODE_W(CODE_W)) u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (enc_valid_i),
        .data_i  (enc_data_i),
        .valid_o (enc_valid_o),
        .code_o  (enc_code_o)
    );

    hsc_decoder #(.DATA_W(DATA_W), .PAR_W(PAR_W), .CODE_W(CODE_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (dec_valid_i),
        .code_i   (dec_code_i),
        .valid_o  (dec_valid_o),
        .data_o   (dec_data_o),
        .syn_o    (dec_syndrome_o),
        .fixed_o  (dec_fixed_o),
        .uncorr_o (dec_uncorr_o)
    );

    // Immediate check of the derived width (R1).
    initial begin
        a_r1_width: assert ((1 << PAR_W) >= CODE_W + 1 && (1 << (PAR_W - 1)) < DATA_W + PAR_W);
    end

endmodule

// File: tb/hsc_codec_test.sv
module hsc_codec_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    // 4-bit configuration
    logic       e_vi = 0, d_vi = 0;
    logic [3:0] e_d = '0;
    logic [6:0] d_c = '0;
    logic       e_vo, d_vo, d_f, d_u;
    logic [6:0] e_c;
    logic [3:0] d_d;
    logic [2:0] d_s;

    // 5-bit configuration
    logic       e_vi5 = 0, d_vi5 = 0;
    logic [4:0] e_d5 = '0;
    logic [8:0] d_c5 = '0;
    logic       e_vo5, d_vo5, d_f5, d_u5;
    logic [8:0] e_c5;
    logic [4:0] d_d5;
    logic [3:0] d_s5;

    hsc_codec #(.DATA_W(4)) uut (
        .clk(clk), .rst_n(rst_n),
        .enc_valid_i(e_vi), .enc_data_i(e_d), .enc_valid_o(e_vo), .enc_code_o(e_c),
        .dec_valid_i(d_vi), .dec_code_i(d_c), .dec_valid_o(d_vo), .dec_data_o(d_d),
        .dec_syndrome_o(d_s), .dec_fixed_o(d_f), .dec_uncorr_o(d_u)
    );

    hsc_codec #(.DATA_W(5)) uut_w5 (
        .clk(clk), .rst_n(rst_n),
        .enc_valid_i(e_vi5), .enc_data_i(e_d5), .enc_valid_o(e_vo5), .enc_code_o(e_c5),
        .dec_valid_i(d_vi5), .dec_code_i(d_c5), .dec_valid_o(d_vo5), .dec_data_o(d_d5),
        .dec_syndrome_o(d_s5), .dec_fixed_o(d_f5), .dec_uncorr_o(d_u5)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit pow2(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    // Expected codeword from the placement and even-parity rules.
    function automatic int exp_enc(input int data, input int n);
        int w, idx, par;
        w = 0; idx = 0;
        for (int p = 1; p <= n; p++)
            if (!pow2(p)) begin
                w = w | (((data >> idx) & 1) << (p - 1));
                idx++;
            end
        for (int j = 0; (1 << j) <= n; j++) begin
            par = 0;
            for (int p = 1; p <= n; p++)
                if (((p >> j) & 1) == 1 && ((w >> (p - 1)) & 1) == 1) par ^= 1;
            w = w | (par << ((1 << j) - 1));
        end
        return w;
    endfunction

    // Expected syndrome: XOR of the indices of all set positions.
    function automatic int exp_syn(input int code, input int n);
        int s;
        s = 0;
        for (int p = 1; p <= n; p++)
            if (((code >> (p - 1)) & 1) == 1) s ^= p;
        return s;
    endfunction

    function automatic int extract(input int code, input int n);
        int d, idx;
        d = 0; idx = 0;
        for (int p = 1; p <= n; p++)
            if (!pow2(p)) begin
                d = d | (((code >> (p - 1)) & 1) << idx);
                idx++;
            end
        return d;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int s, c, exp_d;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(e_vo == 0 && e_c == 0, "R9 enc reset", int'(e_c), 0);
        chk(d_vo == 0 && d_d == 0 && d_s == 0 && !d_f && !d_u, "R9 dec reset", int'(d_d), 0);
        chk(d_vo5 == 0 && d_s5 == 0, "R9 dec5 reset", int'(d_s5), 0);
        rst_n = 1'b1;
        step();
        chk(e_vo == 0 && d_vo == 0, "R8 idle valid", int'(e_vo), 0);

        // R1: widths
        chk($bits(e_c) == 7 && $bits(d_s) == 3, "R1 width m4", $bits(e_c), 7);
        chk($bits(e_c5) == 9 && $bits(d_s5) == 4, "R1 width m5", $bits(e_c5), 9);

        // R2: given example
        e_vi = 1; e_d = 4'b1010;
        step();
        chk(e_vo == 1, "R8 enc valid", int'(e_vo), 1);
        chk(e_c == 7'b1010010, "R2 example 1010", int'(e_c), 7'b1010010);

        // R4/R5: given received word
        e_vi = 0; d_vi = 1; d_c = 7'b1110010;
        step();
        chk(d_s == 3'b110, "R4 syndrome 110", int'(d_s), 6);
        chk(d_d == 4'b1010 && d_f && !d_u, "R5 repair pos6", int'(d_d), 4'b1010);

        // R8: hold while input valid is low
        d_vi = 0; d_c = 7'b0000001; e_d = 4'b0101;
        step();
        chk(d_vo == 0 && d_s == 3'b110 && d_d == 4'b1010, "R8 dec hold", int'(d_d), 4'b1010);
        chk(e_vo == 0 && e_c == 7'b1010010, "R8 enc hold", int'(e_c), 7'b1010010);

        // R4: 5-bit flip at position 5 on data 10110
        d_vi5 = 1;
        d_c5 = 9'(exp_enc(5'b10110, 9) ^ (1 << 4));
        step();
        chk(d_s5 == 4'b0101, "R4 m5 syndrome 0101", int'(d_s5), 5);
        chk(d_d5 == 5'b10110 && d_f5, "R5 m5 repair pos5", int'(d_d5), 5'b10110);
        d_vi5 = 0;

        // R2/R3: encoder sweeps
        e_vi = 1;
        for (int v = 0; v < 16; v++) begin
            e_d = 4'(v);
            step();
            chk(int'(e_c) == exp_enc(v, 7), "R2 R3 enc sweep m4", int'(e_c), exp_enc(v, 7));
        end
        e_vi = 0;
        e_vi5 = 1;
        for (int v = 0; v < 32; v++) begin
            e_d5 = 5'(v);
            step();
            chk(int'(e_c5) == exp_enc(v, 9), "R2 R3 enc sweep m5", int'(e_c5), exp_enc(v, 9));
        end
        e_vi5 = 0;

        // R4-R7: every received word, 4-bit configuration
        d_vi = 1;
        for (int v = 0; v < 128; v++) begin
            d_c = 7'(v);
            step();
            s = exp_syn(v, 7);
            c = (s != 0 && s <= 7) ? (v ^ (1 << (s - 1))) : v;
            exp_d = extract(c, 7);
            chk(int'(d_s) == s, "R4 syn sweep m4", int'(d_s), s);
            chk(int'(d_d) == exp_d, "R5 R6 data sweep m4", int'(d_d), exp_d);
            chk(d_f == (s != 0) && !d_u, "R5 R6 flags m4", int'(d_f), int'(s != 0));
        end
        d_vi = 0;

        // R4-R7: every received word, 5-bit configuration
        d_vi5 = 1;
        for (int v = 0; v < 512; v++) begin
            d_c5 = 9'(v);
            step();
            s = exp_syn(v, 9);
            c = (s != 0 && s <= 9) ? (v ^ (1 << (s - 1))) : v;
            exp_d = extract(c, 9);
            chk(int'(d_s5) == s, "R4 syn sweep m5", int'(d_s5), s);
            chk(int'(d_d5) == exp_d, "R5 R6 R7 data sweep m5", int'(d_d5), exp_d);
            chk(d_f5 == (s != 0 && s <= 9), "R5 R6 fixed m5", int'(d_f5), int'(s != 0 && s <= 9));
            chk(d_u5 == (s > 9), "R7 uncorr m5", int'(d_u5), int'(s > 9));
        end
        d_vi5 = 0;
        step();
        chk(d_vo5 == 0, "R8 dec5 valid drop", int'(d_vo5), 0);

        // R9: reset again clears outputs
        rst_n = 0;
        step();
        chk(d_vo5 == 0 && d_d5 == 0 && !d_f5 && !d_u5 && e_c == 0, "R9 re-reset", int'(d_d5), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule